// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two tri-state buses, A and B, and passes a word of parameterised width in either direction. Each side owns a storage register. The A register samples bus A and the B register samples bus B, each under its own capture strobe on the rising clock edge. A word crossing the block in either direction can be the value present on the opposite bus at that moment or the word held in that side's register. A per-direction source select makes that choice.

An active-low enable and a direction input decide which bus, if any, the block drives. The bus that is not driven is released to high impedance on every bit, so that another agent can drive it. With the enable high, neither bus is driven, but both registers can still capture whatever the outside agents put on the buses. The block therefore supports four uses: live transfer from A to B, live transfer from B to A, capture of one or both buses into storage, and replay of stored words onto either bus.

Top module: `bus_xcvr_reg`

## Requirements
- R1: A synchronous active-high reset `rst` clears both registers to zero. After reset, selecting stored data drives zero onto the driven bus.
- R2: When `capA` is 1 at a rising clock edge, the A register takes the value on bus A. When `capA` is 0 at an edge, the A register keeps its value.
- R3: When `capB` is 1 at a rising clock edge, the B register takes the value on bus B. When `capB` is 0 at an edge, the B register keeps its value.
- R4: With `enN`=0 and `dirAtoB`=1, the block drives bus B with the A-to-B path and releases bus A on every bit.
- R5: With `enN`=0 and `dirAtoB`=0, the block drives bus A with the B-to-A path and releases bus B on every bit.
- R6: With `enN`=1, both buses are released on every bit. The capture behaviour of R2 and R3 still applies.
- R7: The A-to-B path carries live bus A when `selAB`=0 and the A register when `selAB`=1.
- R8: The B-to-A path carries live bus B when `selBA`=0 and the B register when `selBA`=1.
- R9: Toggling a source select produces no intermediate value. Each path always equals either its live input or its register, and it stays unchanged across a select change when those two agree and hold steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both registers |
| rst | input | 1 | Synchronous active-high reset of both registers |
| capA | input | 1 | Capture strobe for the A register (samples bus A) |
| capB | input | 1 | Capture strobe for the B register (samples bus B) |
| selAB | input | 1 | A-to-B source: 0 live bus A, 1 A register |
| selBA | input | 1 | B-to-A source: 0 live bus B, 1 B register |
| enN | input | 1 | Active-low output enable |
| dirAtoB | input | 1 | Direction: 1 drive bus B, 0 drive bus A |
| busA | inout | WIDTH | Bus A, tri-state |
| busB | inout | WIDTH | Bus B, tri-state |

## Verification
Random words drive each of the three enable and direction modes, and both select values are applied in each mode. This separates a live pass-through from a stored replay and shows which side an output comes from. Whenever a bus should be released, the bench drives its own word on that bus and expects to read it back unchanged. Any contention from the block would corrupt that word. Capture strobes are randomised independently of the mode, so a capture made with the enable high shows up later when the stored word is replayed. A directed sequence first checks the zero value after reset.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;
  typedef struct packed {
    logic driveA;
    logic driveB;
    logic pickRegAB;
    logic pickRegBA;
    logic loadA;
    logic loadB;
  } xcvr_ctl_t;
endpackage

// File: rtl/bus_xcvr_ctrl.sv
module bus_xcvr_ctrl
  import bus_xcvr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       capA,
  input  logic       capB,
  input  logic       selAB,
  input  logic       selBA,
  input  logic       enN,
  input  logic       dirAtoB,
  output xcvr_ctl_t  ctl
);
  always_comb begin
    ctl.driveA    = !enN && !dirAtoB;
    ctl.driveB    = !enN && dirAtoB;
    ctl.pickRegAB = selAB;
    ctl.pickRegBA = selBA;
    ctl.loadA     = capA;
    ctl.loadB     = capB;
  end

  // R4
  never_both_driven_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.driveA, ctl.driveB}));

  // R6
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    enN |-> !(ctl.driveA || ctl.driveB));
endmodule

// File: rtl/bus_xcvr_datapath.sv
module bus_xcvr_datapath
  import bus_xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  xcvr_ctl_t        ctl,
  input  logic [WIDTH-1:0] busAIn,
  input  logic [WIDTH-1:0] busBIn,
  output logic [WIDTH-1:0] pathAB,
  output logic [WIDTH-1:0] pathBA,
  output logic             oeA,
  output logic             oeB
);
  logic [WIDTH-1:0] regA;
  logic [WIDTH-1:0] regB;

  always_ff @(posedge clk) begin
    if (rst) begin
      regA <= '0;
      regB <= '0;
    end else begin
      if (ctl.loadA) regA <= busAIn;
      if (ctl.loadB) regB <= busBIn;
    end
  end

  assign pathAB = ctl.pickRegAB ? regA : busAIn;
  assign pathBA = ctl.pickRegBA ? regB : busBIn;
  assign oeA    = ctl.driveA;
  assign oeB    = ctl.driveB;

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (regA == '0 && regB == '0));

  // R2
  capture_a_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.loadA |=> regA == $past(busAIn));

  // R3
  hold_b_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl.loadB |=> $stable(regB));

  // R9
  path_source_chk: assert property (@(posedge clk) disable iff (rst)
    (pathAB == busAIn || pathAB == regA) && (pathBA == busBIn || pathBA == regB));

  // R9
  no_glitch_chk: assert property (@(posedge clk) disable iff (rst)
    (busAIn == regA && $stable(busAIn) && $stable(regA)) |-> $stable(pathAB));
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import bus_xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capA,
  input  logic             capB,
  input  logic             selAB,
  input  logic             selBA,
  input  logic             enN,
  input  logic             dirAtoB,
  inout  wire  [WIDTH-1:0] busA,
  inout  wire  [WIDTH-1:0] busB
);
  xcvr_ctl_t        ctl;
  logic [WIDTH-1:0] pathAB;
  logic [WIDTH-1:0] pathBA;
  logic             oeA;
  logic             oeB;

  bus_xcvr_ctrl u_ctrl (
    .clk(clk), .rst(rst), .capA(capA), .capB(capB),
    .selAB(selAB), .selBA(selBA), .enN(enN), .dirAtoB(dirAtoB),
    .ctl(ctl)
  );

  bus_xcvr_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl),
    .busAIn(busA), .busBIn(busB),
    .pathAB(pathAB), .pathBA(pathBA),
    .oeA(oeA), .oeB(oeB)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign busA[i] = oeA ? pathBA[i] : 1'bz;
    assign busB[i] = oeB ? pathAB[i] : 1'bz;
  end
endmodule

// File: tb/tb_bus_xcvr_reg.sv
module tb_bus_xcvr_reg;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst, capA, capB, selAB, selBA, enN, dirAtoB;
  logic [W-1:0] tbA, tbB;
  logic tbAEn, tbBEn;
  wire  [W-1:0] busA, busB;
  logic [W-1:0] mA, mB;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign busA = tbAEn ? tbA : {W{1'bz}};
  assign busB = tbBEn ? tbB : {W{1'bz}};

  bus_xcvr_reg #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .capA(capA), .capB(capB),
    .selAB(selAB), .selBA(selBA), .enN(enN), .dirAtoB(dirAtoB),
    .busA(busA), .busB(busB)
  );

  function automatic logic [W-1:0] expAB(logic s, logic [W-1:0] live, logic [W-1:0] st);
    return s ? st : live;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One step: inputs applied after negedge, outputs checked, then the edge.
  task automatic step(logic e, logic d, logic sa, logic sb, logic ca, logic cb,
                      logic [W-1:0] va, logic [W-1:0] vb);
    logic [W-1:0] seenA, seenB;
    @(negedge clk);
    enN = e; dirAtoB = d; selAB = sa; selBA = sb; capA = ca; capB = cb;
    tbA = va; tbB = vb;
    tbAEn = e || !d;
    tbBEn = e || d;
    tbAEn = !(!e && !d);
    tbBEn = !(!e && d);
    #1;
    if (!e && d) begin
      seenA = va;
      seenB = expAB(sa, va, mA);
      check("R4/R7 bus B driven", busB, seenB);
      check("R4 bus A released", busA, va);
    end else if (!e && !d) begin
      seenB = vb;
      seenA = expAB(sb, vb, mB);
      check("R5/R8 bus A driven", busA, seenA);
      check("R5 bus B released", busB, vb);
    end else begin
      seenA = va; seenB = vb;
      check("R6 bus A released", busA, va);
      check("R6 bus B released", busB, vb);
    end
    @(posedge clk);
    if (ca) mA = seenA;  // R2
    if (cb) mB = seenB;  // R3
  endtask

  initial begin
    rst = 1'b1; capA = 0; capB = 0; selAB = 0; selBA = 0; enN = 1; dirAtoB = 0;
    tbA = '0; tbB = '0; tbAEn = 1; tbBEn = 1;
    mA = '0; mB = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: stored replay after reset gives zero
    step(0, 1, 1, 0, 0, 0, 8'h5A, 8'h00);
    check("R1 A register zero", busB, 8'h00);
    step(0, 0, 0, 1, 0, 0, 8'h00, 8'hC3);
    check("R1 B register zero", busA, 8'h00);

    // R6 with R2/R3: capture while both buses released, then replay
    step(1, 0, 0, 0, 1, 1, 8'hA5, 8'h3C);
    step(0, 1, 1, 0, 0, 0, 8'h11, 8'h00);
    check("R6/R2 captured A replayed", busB, 8'hA5);
    step(0, 0, 0, 1, 0, 0, 8'h00, 8'h22);
    check("R6/R3 captured B replayed", busA, 8'h3C);

    // R2/R3 hold: no capture strobes, stored values unchanged
    step(1, 0, 0, 0, 0, 0, 8'hFF, 8'hFF);
    step(0, 1, 1, 0, 0, 0, 8'h00, 8'h00);
    check("R2 hold A", busB, 8'hA5);
    step(0, 0, 0, 1, 0, 0, 8'h00, 8'h00);
    check("R3 hold B", busA, 8'h3C);

    // R9: live equals stored, toggle select, output constant
    step(0, 1, 0, 0, 0, 0, 8'hA5, 8'h00);
    check("R9 live side", busB, 8'hA5);
    step(0, 1, 1, 0, 0, 0, 8'hA5, 8'h00);
    check("R9 stored side", busB, 8'hA5);

    // Random mix covering R4 R5 R6 R7 R8 with captures
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 400; i++) begin
      logic [2:0] m;
      m = 3'($urandom % 3);
      step(m == 2, m == 1, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           W'($urandom), W'($urandom));
    end
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule